// File: doc/BRIEF.md
# Microsequencer with Return Stack and Table Dispatch

This block chooses the next micro-program address for a 12-bit microcode store. Each cycle it receives the decoded control fields of the instruction that is executing. It then produces the address of the next fetch. The store fetches one instruction ahead, so the `pc` output is always one address past the instruction that is executing. The instruction that sits directly after a transfer (the slot) therefore runs unless the transfer asks for it to be dropped.

Transfers come from two sources:
- a conditional jump, which carries its target and control bits in the instruction;
- a table dispatch, which reads the target and control bits from a 1024-entry table.

The table is indexed by a bit field pulled out of a rotated 32-bit operand and merged with a base offset. Two control bits select one of four actions: plain jump, call, return, or a microcode write that reuses the call path. A third bit drops the slot instruction. A separate pop request on any instruction performs a return.

Return addresses live in a 32-entry wrapping stack. The microcode store itself is external: the block only provides a write strobe and the address for it.

Top module: `useq`

## Requirements
- R1: While reset is held and in the first cycle after release, `pc` is 0, `execSquash` is 0 and `ucodeWe` is 0. An instruction that takes no transfer makes `pc` step by one at the next edge.
- R2: A jump (`opKind`=1) tests one condition chosen by `condSel`:
  - 0: bit 0 of `mWord` rotated right by `mRot`;
  - 1: `aluCarry`;
  - 2: `aluZero`;
  - 3: `aluOverflow`.

  When the condition is true the transfer is taken. When it is false, `pc` steps by one and the stack is left alone.
- R3: After a taken transfer whose N bit is 0, the slot instruction is executed normally, including any transfer it takes.
- R4: After a taken transfer whose N bit is 1, `execSquash` is 1 in the next cycle. The instruction inputs of that cycle are ignored and `pc` steps by one.
- R5: Control bits P=1, R=0 (call) load the target and push the current `pc` plus one, which is the branch instruction's address plus two.
- R6: Control bits P=0, R=1 (return) load the most recently pushed value, ignore the target and pop the stack.
- R7: `popBit` on an instruction that takes no transfer performs a return, and the following instruction is not squashed.
- R8: A dispatch (`opKind`=2) reads table entry `dispOffset | (rotr(mWord, mRot) & ((1<<w)-1))`, where w = min(`fieldWidth`, 8). The entry layout is: bit 14 = N, bit 13 = P, bit 12 = R, bits 11:0 = target. A dispatch is always taken.
- R9: The table is loaded through `dramWe`/`dramAddr`/`dramData` at a clock edge. A dispatch in a later cycle sees the new contents.
- R10: The write transfer (P=1, R=1) behaves as a call. It then runs a three-cycle sequence:
  - in the cycle after it, `ucodeWe` is 1 for exactly one cycle with `ucodeAddr` equal to the target;
  - in the next cycle, a forced return with N set runs;
  - `execSquash` is 1 in the two cycles after the strobe.
- R11: The stack pointer wraps modulo 32. The 33rd push overwrites the first, and the 33rd pop after 33 pushes returns the 33rd pushed value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opKind | input | 2 | 0 no transfer, 1 conditional jump, 2 dispatch |
| popBit | input | 1 | Return request on any instruction |
| jumpPc | input | 12 | Jump target |
| jumpN | input | 1 | Jump: squash slot |
| jumpP | input | 1 | Jump: P control bit |
| jumpR | input | 1 | Jump: R control bit |
| condSel | input | 2 | Jump condition select |
| aluCarry | input | 1 | ALU carry flag |
| aluZero | input | 1 | ALU zero flag |
| aluOverflow | input | 1 | ALU overflow flag |
| mWord | input | 32 | Selected M operand |
| mRot | input | 5 | Right-rotate amount for M operand |
| fieldWidth | input | 4 | Dispatch field width (clamped to 8) |
| dispOffset | input | 10 | Dispatch base offset |
| dramWe | input | 1 | Dispatch table write enable |
| dramAddr | input | 10 | Dispatch table write address |
| dramData | input | 15 | Dispatch table write data |
| pc | output | 12 | Address being fetched |
| execSquash | output | 1 | Current instruction inputs are not executed |
| ucodeWe | output | 1 | Microcode store write strobe |
| ucodeAddr | output | 12 | Microcode store write address |

## Verification
The assertions assume that the microcode keeps clear of conflicting requests:
- the pop bit is never combined with a taken transfer;
- the slot of a write transfer holds no transfer of its own;
- no instruction both pushes and pops.

The stimulus keeps to these rules by placing the pop bit only on plain instructions and by filling write slots with plain instructions. In squashed cycles the stimulus presents a taken call on purpose. Its push would corrupt the return addresses checked later, so the bench can detect any leak of a squashed instruction.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    OP_SEQ  = 2'd0,
    OP_JUMP = 2'd1,
    OP_DISP = 2'd2,
    OP_RSVD = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    PC_INC  = 2'd0,
    PC_JUMP = 2'd1,
    PC_DISP = 2'd2,
    PC_POP  = 2'd3
  } pcSel_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   push;
    logic   pop;
  } seqStrobe_t;
endpackage

// File: rtl/useq_datapath.sv
module useq_datapath
  import useq_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int STACK_DEPTH = 32,
  parameter int DRAM_DEPTH  = 1024,
  parameter int M_W         = 32,
  parameter int FIELD_MAX   = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  seqStrobe_t                     strb,
  input  logic [PC_W-1:0]                jumpPc,
  input  logic [M_W-1:0]                 mWord,
  input  logic [$clog2(M_W)-1:0]         mRot,
  input  logic [$clog2(FIELD_MAX+1)-1:0] fieldWidth,
  input  logic [$clog2(DRAM_DEPTH)-1:0]  dispOffset,
  input  logic                           dramWe,
  input  logic [$clog2(DRAM_DEPTH)-1:0]  dramAddr,
  input  logic [PC_W+2:0]                dramData,
  output logic [PC_W-1:0]                pc,
  output logic                           condBit,
  output logic [2:0]                     dispXfer
);
  localparam int SP_W    = $clog2(STACK_DEPTH);
  localparam int DRAM_AW = $clog2(DRAM_DEPTH);
  localparam int ROT_W   = $clog2(M_W);
  localparam int WID_W   = $clog2(FIELD_MAX + 1);
  localparam int ENT_W   = PC_W + 3;

  // Rotator: only the low bits feed the table index and the condition.
  logic [DRAM_AW-1:0] rotLow;
  for (genvar i = 0; i < DRAM_AW; i++) begin : g_rot
    assign rotLow[i] = mWord[ROT_W'(i) + mRot];
  end
  assign condBit = rotLow[0];

  // Field mask, width clamped to FIELD_MAX.
  logic [WID_W-1:0]   widthEff;
  logic [DRAM_AW-1:0] fieldMask;
  assign widthEff = (fieldWidth > WID_W'(FIELD_MAX)) ? WID_W'(FIELD_MAX) : fieldWidth;
  for (genvar i = 0; i < DRAM_AW; i++) begin : g_mask
    assign fieldMask[i] = (i < int'(widthEff));
  end

  logic [DRAM_AW-1:0] dispAddr;
  assign dispAddr = dispOffset | (rotLow & fieldMask);

  // Dispatch table with a separate synchronous load port.
  logic [ENT_W-1:0] dram [DRAM_DEPTH];
  logic [ENT_W-1:0] dispEntry;
  always_ff @(posedge clk) begin
    if (dramWe) dram[dramAddr] <= dramData;
  end
  assign dispEntry = dram[dispAddr];
  assign dispXfer  = dispEntry[ENT_W-1 -: 3];

  // Return stack.
  logic [PC_W-1:0] stackMem [STACK_DEPTH];
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] spDec;
  logic [PC_W-1:0] stackTop;
  logic [PC_W-1:0] pcInc;
  logic [PC_W-1:0] pcNext;

  assign spDec    = sp - 1'b1;
  assign stackTop = stackMem[spDec];
  assign pcInc    = pc + 1'b1;

  always_comb begin
    unique case (strb.pcSel)
      PC_JUMP: pcNext = jumpPc;
      PC_DISP: pcNext = dispEntry[PC_W-1:0];
      PC_POP:  pcNext = stackTop;
      default: pcNext = pcInc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strb.push) stackMem[sp] <= pcInc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0;
      sp <= '0;
    end else begin
      pc <= pcNext;
      if (strb.push)     sp <= sp + 1'b1;
      else if (strb.pop) sp <= spDec;
    end
  end

  // R1: a non-transfer step advances by one.
  p_seq_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pcSel == PC_INC) |=> (pc == $past(pc) + 1'b1));

  // R5: the saved return is the fetch address plus one.
  p_push_saves_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> (stackTop == $past(pc) + 1'b1));

  // R6: a pop lands on the previously saved address.
  p_pop_lands_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> (pc == $past(stackTop)));

  // R11: the pointer moves by exactly one per push, modulo depth.
  p_push_ptr_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> (sp == $past(sp) + 1'b1));
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] opKind,
  input  logic       popBit,
  input  logic       jumpN,
  input  logic       jumpP,
  input  logic       jumpR,
  input  logic [1:0] condSel,
  input  logic       aluCarry,
  input  logic       aluZero,
  input  logic       aluOverflow,
  input  logic       condBit,
  input  logic [2:0] dispXfer,
  output seqStrobe_t strb,
  output logic       execSquash,
  output logic       ucodeWe
);
  logic   killNow;
  logic   wrPend;
  logic   retPend;
  logic   setKill;
  logic   setWr;
  logic   condMet;
  logic   taken;
  logic   xN;
  logic   xP;
  logic   xR;
  pcSel_e tgtSel;

  always_comb begin
    unique case (condSel)
      2'd0:    condMet = condBit;
      2'd1:    condMet = aluCarry;
      2'd2:    condMet = aluZero;
      default: condMet = aluOverflow;
    endcase
  end

  always_comb begin
    taken  = 1'b0;
    xN     = 1'b0;
    xP     = 1'b0;
    xR     = 1'b0;
    tgtSel = PC_JUMP;
    unique case (opKind_e'(opKind))
      OP_JUMP: begin
        taken = condMet;
        {xN, xP, xR} = {jumpN, jumpP, jumpR};
      end
      OP_DISP: begin
        taken  = 1'b1;
        {xN, xP, xR} = dispXfer;
        tgtSel = PC_DISP;
      end
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    strb    = '{pcSel: PC_INC, push: 1'b0, pop: 1'b0};
    setKill = 1'b0;
    setWr   = 1'b0;
    if (retPend) begin
      // Forced return that replaces the written location's fetch.
      strb.pcSel = PC_POP;
      strb.pop   = 1'b1;
      setKill    = 1'b1;
    end else if (!killNow) begin
      if (taken) begin
        setKill = xN;
        unique case ({xP, xR})
          2'b00: strb.pcSel = tgtSel;
          2'b10: begin
            strb.pcSel = tgtSel;
            strb.push  = 1'b1;
          end
          2'b01: begin
            strb.pcSel = PC_POP;
            strb.pop   = 1'b1;
          end
          default: begin
            strb.pcSel = tgtSel;
            strb.push  = 1'b1;
            setWr      = 1'b1;
          end
        endcase
      end else if (popBit) begin
        strb.pcSel = PC_POP;
        strb.pop   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      killNow <= 1'b0;
      wrPend  <= 1'b0;
      retPend <= 1'b0;
    end else begin
      killNow <= setKill;
      wrPend  <= setWr;
      retPend <= wrPend;
    end
  end

  assign execSquash = killNow | retPend;
  assign ucodeWe    = wrPend;

  // R5: one instruction never both pushes and pops.
  p_no_push_pop_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.push && strb.pop));

  // R4: a dropped slot touches neither the stack nor the target.
  p_squash_inert_r4: assert property (@(posedge clk) disable iff (!rstN)
    (killNow && !retPend) |-> (!strb.push && !strb.pop && strb.pcSel == PC_INC));

  // R10: the write strobe lasts one cycle and is followed by the forced return.
  p_we_one_shot_r10: assert property (@(posedge clk) disable iff (!rstN)
    ucodeWe |=> (!ucodeWe && execSquash && strb.pop));

  // R10: the forced return drops the following fetch.
  p_ret_then_kill_r10: assert property (@(posedge clk) disable iff (!rstN)
    (retPend && !ucodeWe) |=> (execSquash && !ucodeWe));
endmodule

// File: rtl/useq.sv
module useq
  import useq_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int STACK_DEPTH = 32,
  parameter int DRAM_DEPTH  = 1024,
  parameter int M_W         = 32,
  parameter int FIELD_MAX   = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [1:0]                     opKind,
  input  logic                           popBit,
  input  logic [PC_W-1:0]                jumpPc,
  input  logic                           jumpN,
  input  logic                           jumpP,
  input  logic                           jumpR,
  input  logic [1:0]                     condSel,
  input  logic                           aluCarry,
  input  logic                           aluZero,
  input  logic                           aluOverflow,
  input  logic [M_W-1:0]                 mWord,
  input  logic [$clog2(M_W)-1:0]         mRot,
  input  logic [$clog2(FIELD_MAX+1)-1:0] fieldWidth,
  input  logic [$clog2(DRAM_DEPTH)-1:0]  dispOffset,
  input  logic                           dramWe,
  input  logic [$clog2(DRAM_DEPTH)-1:0]  dramAddr,
  input  logic [PC_W+2:0]                dramData,
  output logic [PC_W-1:0]                pc,
  output logic                           execSquash,
  output logic                           ucodeWe,
  output logic [PC_W-1:0]                ucodeAddr
);
  seqStrobe_t strb;
  logic       condBit;
  logic [2:0] dispXfer;

  useq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opKind     (opKind),
    .popBit     (popBit),
    .jumpN      (jumpN),
    .jumpP      (jumpP),
    .jumpR      (jumpR),
    .condSel    (condSel),
    .aluCarry   (aluCarry),
    .aluZero    (aluZero),
    .aluOverflow(aluOverflow),
    .condBit    (condBit),
    .dispXfer   (dispXfer),
    .strb       (strb),
    .execSquash (execSquash),
    .ucodeWe    (ucodeWe)
  );

  useq_datapath #(
    .PC_W       (PC_W),
    .STACK_DEPTH(STACK_DEPTH),
    .DRAM_DEPTH (DRAM_DEPTH),
    .M_W        (M_W),
    .FIELD_MAX  (FIELD_MAX)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .jumpPc    (jumpPc),
    .mWord     (mWord),
    .mRot      (mRot),
    .fieldWidth(fieldWidth),
    .dispOffset(dispOffset),
    .dramWe    (dramWe),
    .dramAddr  (dramAddr),
    .dramData  (dramData),
    .pc        (pc),
    .condBit   (condBit),
    .dispXfer  (dispXfer)
  );

  assign ucodeAddr = pc;
endmodule

// File: tb/tb_useq.sv
module tb_useq;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  opKind;
  logic        popBit;
  logic [11:0] jumpPc;
  logic        jumpN, jumpP, jumpR;
  logic [1:0]  condSel;
  logic        aluCarry, aluZero, aluOverflow;
  logic [31:0] mWord;
  logic [4:0]  mRot;
  logic [3:0]  fieldWidth;
  logic [9:0]  dispOffset;
  logic        dramWe;
  logic [9:0]  dramAddr;
  logic [14:0] dramData;
  logic [11:0] pc;
  logic        execSquash, ucodeWe;
  logic [11:0] ucodeAddr;

  always #4 clk = ~clk;

  useq dut (.*);

  typedef struct {
    logic [11:0] pc;
    logic        sq;
    logic        we;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   finished = 0;

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic check(string tag, logic [11:0] aPc, logic aSq, logic aWe, logic [11:0] aAddr,
                       logic [11:0] ePc, logic eSq, logic eWe);
    vectors++;
    if (aPc !== ePc || aSq !== eSq || aWe !== eWe || (eWe && aAddr !== ePc)) begin
      miscompares++;
      $display("FAIL %s: pc=%h sq=%b we=%b addr=%h expected pc=%h sq=%b we=%b addr=%h",
               tag, aPc, aSq, aWe, aAddr, ePc, eSq, eWe, ePc);
    end
  endtask

  // Monitor: compares after every edge that has a pending expectation.
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.tag, pc, execSquash, ucodeWe, ucodeAddr, e.pc, e.sq, e.we);
    end
  end

  initial begin
    #(8 * 100000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finishRun();
  end

  task automatic clrIn();
    opKind = 2'd0; popBit = 1'b0; jumpPc = '0;
    jumpN = 1'b0; jumpP = 1'b0; jumpR = 1'b0;
    condSel = 2'd0; aluCarry = 1'b0; aluZero = 1'b0; aluOverflow = 1'b0;
    mWord = '0; mRot = '0; fieldWidth = '0; dispOffset = '0;
  endtask

  task automatic seqOp(logic pb);
    clrIn(); popBit = pb;
  endtask

  // flags = {overflow, zero, carry}
  task automatic jmp(logic [11:0] t, logic n, logic p, logic r, logic [1:0] cs,
                     logic [2:0] flags, logic [31:0] mw, logic [4:0] mr);
    clrIn();
    opKind = 2'd1; jumpPc = t; jumpN = n; jumpP = p; jumpR = r; condSel = cs;
    {aluOverflow, aluZero, aluCarry} = flags; mWord = mw; mRot = mr;
  endtask

  task automatic disp(logic [9:0] off, logic [31:0] mw, logic [4:0] mr, logic [3:0] w);
    clrIn();
    opKind = 2'd2; dispOffset = off; mWord = mw; mRot = mr; fieldWidth = w;
  endtask

  // Junk for squashed cycles: a taken call that must have no effect.
  task automatic junk();
    jmp(12'h777, 1'b0, 1'b1, 1'b0, 2'd1, 3'b001, 32'h0, 5'd0);
  endtask

  task automatic step(logic [11:0] ePc, logic eSq, logic eWe, string tag);
    exp_t e;
    e.pc = ePc; e.sq = eSq; e.we = eWe; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic dramLoad(logic [9:0] a, logic [14:0] d);
    dramWe = 1'b1; dramAddr = a; dramData = d;
    @(negedge clk);
    dramWe = 1'b0;
  endtask

  initial begin
    clrIn();
    dramWe = 1'b0; dramAddr = '0; dramData = '0;
    rstN = 1'b0;
    @(negedge clk);
    // Table entries: {N,P,R,target}
    dramLoad(10'h2A5, {3'b000, 12'h123});
    dramLoad(10'h3A5, {3'b110, 12'h456});
    dramLoad(10'h0FF, {3'b000, 12'h1EE});
    dramLoad(10'h155, {3'b000, 12'h0AA});
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 reset", pc, execSquash, ucodeWe, ucodeAddr, 12'h000, 1'b0, 1'b0);

    seqOp(0); step(12'h001, 0, 0, "R1 seq");
    seqOp(0); step(12'h002, 0, 0, "R1 seq");
    seqOp(0); step(12'h003, 0, 0, "R1 seq");

    jmp(12'h100, 0, 0, 0, 2'd1, 3'b001, 0, 0); step(12'h100, 0, 0, "R2 carry taken");
    jmp(12'h200, 0, 0, 0, 2'd1, 3'b001, 0, 0); step(12'h200, 0, 0, "R2 taken");
    jmp(12'h210, 0, 0, 0, 2'd1, 3'b001, 0, 0); step(12'h210, 0, 0, "R3 slot transfer honored");
    seqOp(0); step(12'h211, 0, 0, "R1 seq");
    jmp(12'h2F0, 0, 0, 0, 2'd2, 3'b001, 0, 0); step(12'h212, 0, 0, "R2 zero false falls through");
    jmp(12'h220, 0, 0, 0, 2'd3, 3'b100, 0, 0); step(12'h220, 0, 0, "R2 overflow taken");

    jmp(12'h300, 1, 0, 0, 2'd0, 3'b000, 32'h20, 5'd5); step(12'h300, 1, 0, "R4 M bit taken with N");
    junk(); step(12'h301, 0, 0, "R4 squashed inputs ignored");
    jmp(12'h3F0, 0, 0, 0, 2'd0, 3'b111, 32'h20, 5'd4); step(12'h302, 0, 0, "R2 M bit false");

    jmp(12'h040, 0, 1, 0, 2'd1, 3'b001, 0, 0); step(12'h040, 0, 0, "R5 call");
    seqOp(0); step(12'h041, 0, 0, "R3 slot");
    seqOp(0); step(12'h042, 0, 0, "R1 seq");
    jmp(12'hABC, 1, 0, 1, 2'd1, 3'b001, 0, 0); step(12'h303, 1, 0, "R6 return to call+2");
    junk(); step(12'h304, 0, 0, "R4 squashed");

    jmp(12'h050, 0, 1, 0, 2'd1, 3'b001, 0, 0); step(12'h050, 0, 0, "R5 call");
    seqOp(1); step(12'h305, 0, 0, "R7 pop bit no squash");
    seqOp(0); step(12'h306, 0, 0, "R7 resume");

    disp(10'h2A0, 32'hFFFF_FDFF, 5'd8, 4'd3); step(12'h123, 0, 0, "R8 dispatch field");
    disp(10'h300, 32'h5000_000A, 5'd28, 4'd8); step(12'h456, 1, 0, "R8 rotate wrap, call with N");
    junk(); step(12'h457, 0, 0, "R4 squashed after dispatch");
    seqOp(1); step(12'h124, 0, 0, "R5 dispatch call saved +1");
    disp(10'h000, 32'hFFFF_FFFF, 5'd0, 4'd15); step(12'h1EE, 0, 0, "R8 width clamp");
    disp(10'h155, 32'hFFFF_FFFF, 5'd0, 4'd0); step(12'h0AA, 0, 0, "R8 width zero");

    jmp(12'h7F0, 0, 1, 1, 2'd1, 3'b001, 0, 0); step(12'h7F0, 0, 1, "R10 write strobe");
    seqOp(0); step(12'h7F1, 1, 0, "R10 forced return cycle");
    junk(); step(12'h0AB, 1, 0, "R10 resume squash");
    junk(); step(12'h0AC, 0, 0, "R10 resumed");

    seqOp(0); dramWe = 1'b1; dramAddr = 10'h2A5; dramData = {3'b000, 12'h3C3};
    step(12'h0AD, 0, 0, "R9 load cycle");
    dramWe = 1'b0;
    disp(10'h2A0, 32'hFFFF_FDFF, 5'd8, 4'd3); step(12'h3C3, 0, 0, "R9 reloaded entry");

    // R11 wrap: 33 calls then 33 returns.
    for (int k = 0; k <= 32; k++) begin
      logic [11:0] t;
      t = 12'h800 + 12'(4 * k);
      jmp(t, 1, 1, 0, 2'd1, 3'b001, 0, 0); step(t, 1, 0, "R5 call chain");
      junk(); step(t + 12'd1, 0, 0, "R4 squashed");
    end
    for (int j = 0; j <= 32; j++) begin
      logic [11:0] v;
      v = (j == 0 || j == 32) ? 12'h87E : 12'h800 + 12'(4 * (32 - j)) - 12'd2;
      jmp(12'h123, 1, 0, 1, 2'd1, 3'b001, 0, 0);
      step(v, 1, 0, (j == 32) ? "R11 wrapped pop" : "R6 return chain");
      junk(); step(v + 12'd1, 0, 0, "R4 squashed");
    end

    clrIn();
    @(negedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule